// File: doc/BRIEF.md
# Floating-Point Exception and Status Word Unit

This block keeps the 16-bit status word of a stack-based floating-point unit and raises its exception interrupt request. The arithmetic datapath does not write the word directly. It reports what happened through one-cycle strobes: six exception events, a stack fault with its direction, comparison results and direct condition-code writes. The datapath also drives the current top-of-stack index and a busy level, and the unit copies both into the word.

The exception flags are sticky. Each flag records its condition whatever its mask bit says, and it stays set until the clear-exceptions command. The interrupt request is registered. It is high while any recorded flag has a mask bit of 0 in the control word. Software reads the status word at any time through the `status_word` output.

Top module: `fpu_status_unit`

## Requirements
- R1: An event strobe `exc_evt[i]` sets status bit i on the next clock edge, whatever the mask. The bit order is 0 invalid operation, 1 denormal operand, 2 divide by zero, 3 overflow, 4 underflow, 5 inexact result.
- R2: Once set, an exception flag stays set in later cycles until `clr_exc` is asserted.
- R3: `irq` is registered. After each edge it equals the OR over i of (flag i AND NOT `ctrl_mask[i]`), where the flags are the values just recorded. A mask bit of 1 suppresses its flag. Clearing a mask bit while its flag is set raises `irq` on the next edge.
- R4: A stack-fault strobe sets status bit 6 and writes C1 (bit 9) with `stk_fault_ovf`, where 1 means overflow and 0 means underflow. In the same cycle, this C1 write wins over a comparison or a direct write. Bit 6 stays set until `clr_exc`.
- R5: Status bit 7 is the OR of bits 0 to 5. It does not reflect the stack-fault bit.
- R6: `clr_exc` clears bits 0 to 7 and drops `irq` on the next edge. An event strobed in the same cycle as the clear is still recorded. The clear does not change the condition codes.
- R7: A comparison strobe `cmp_valid` clears C1 and sets {C3,C2,C0} from `cmp_res`: 00 greater gives 000, 01 less gives 001, 10 equal gives 100, 11 unordered gives 111.
- R8: `cc_we` loads `cc_in` = {C3,C2,C1,C0} into status bits 14, 10, 9 and 8. In the same cycle, a comparison wins over this write.
- R9: Status bits 13:11 show `top_in` and bit 15 shows `busy_in`, one cycle after they are presented.
- R10: While `rst` is high, the status word becomes all zero and `irq` goes low on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_evt | input | 6 | Exception event strobes, one per flag |
| stk_fault_evt | input | 1 | Stack fault strobe |
| stk_fault_ovf | input | 1 | Stack fault direction: 1 overflow, 0 underflow |
| cmp_valid | input | 1 | Comparison result strobe |
| cmp_res | input | 2 | Comparison outcome: 00 gt, 01 lt, 10 eq, 11 unordered |
| cc_we | input | 1 | Direct condition-code write strobe |
| cc_in | input | 4 | Condition codes {C3,C2,C1,C0} for a direct write |
| top_in | input | 3 | Current top-of-stack index |
| busy_in | input | 1 | Busy level |
| ctrl_mask | input | 6 | Exception mask bits from the control word, same order as the flags |
| clr_exc | input | 1 | Clear-exceptions command |
| status_word | output | 16 | Registered status word |
| irq | output | 1 | Registered exception interrupt request |

## Verification
Single events are walked across all six flag positions, which tells a misplaced or swapped flag bit from a correct one. Events are then combined and stacked over several cycles, which separates sticky recording from plain pass-through. The mask patterns cover one masked event next to one unmasked event, and a flag that is unmasked only after it was set; these show whether the request depends on the recorded flags or only on the incoming strobe. Collisions in a single cycle (clear with an event, stack fault with a comparison, comparison with a direct write) decide each priority rule, and the four comparison codes tell the condition-code patterns apart.

// File: rtl/fpu_status_pkg.sv
package fpu_status_pkg;
  localparam int NUM_EXC  = 6;
  localparam int TOP_W    = 3;
  localparam int STATUS_W = 16;
  localparam int CC_W     = 4;

  // Bit positions inside the status word
  localparam int SB_STKF  = 6;
  localparam int SB_SUMM  = 7;
  localparam int SB_C0    = 8;
  localparam int SB_C1    = 9;
  localparam int SB_C2    = 10;
  localparam int SB_TOPLO = 11;
  localparam int SB_C3    = 14;
  localparam int SB_BUSY  = 15;

  typedef enum logic [1:0] {
    CMP_GT = 2'b00,
    CMP_LT = 2'b01,
    CMP_EQ = 2'b10,
    CMP_UN = 2'b11
  } cmp_res_e;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
    logic c0;
  } ccode_t;
endpackage

// File: rtl/fpu_exc_flags.sv
module fpu_exc_flags #(
  parameter int NUM_EXC = fpu_status_pkg::NUM_EXC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] evt,
  input  logic               clr,
  output logic [NUM_EXC-1:0] flags,
  output logic [NUM_EXC-1:0] flags_nx,
  output logic               summary
);
  logic [NUM_EXC-1:0] flag_q;
  logic               summ_q;

  // One sticky cell per exception; a new event beats a clear
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_cell
    always_comb begin
      if (evt[i])   flags_nx[i] = 1'b1;
      else if (clr) flags_nx[i] = 1'b0;
      else          flags_nx[i] = flag_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flags_nx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) summ_q <= 1'b0;
    else     summ_q <= |flags_nx;
  end

  assign flags   = flag_q;
  assign summary = summ_q;

  AST_EVENT_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));  // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((flags & $past(flags)) == $past(flags)));  // R2
  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst)
    summary == (|flags));  // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr && (evt == '0)) |=> (flags == '0));  // R6
endmodule

// File: rtl/fpu_cond_codes.sv
module fpu_cond_codes
  import fpu_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sf_evt,
  input  logic       sf_ovf,
  input  logic       clr,
  input  logic       cmp_valid,
  input  logic [1:0] cmp_res,
  input  logic       cc_we,
  input  logic [3:0] cc_in,
  output ccode_t     cc,
  output logic       sf_flag
);
  ccode_t cc_q, cc_n;
  logic   sf_q;

  // Priority, lowest first: direct write, comparison, stack fault direction
  always_comb begin
    cc_n = cc_q;
    if (cc_we) cc_n = ccode_t'(cc_in);
    if (cmp_valid) begin
      cc_n.c1 = 1'b0;
      unique case (cmp_res_e'(cmp_res))
        CMP_GT: {cc_n.c3, cc_n.c2, cc_n.c0} = 3'b000;
        CMP_LT: {cc_n.c3, cc_n.c2, cc_n.c0} = 3'b001;
        CMP_EQ: {cc_n.c3, cc_n.c2, cc_n.c0} = 3'b100;
        CMP_UN: {cc_n.c3, cc_n.c2, cc_n.c0} = 3'b111;
        default: ;
      endcase
    end
    if (sf_evt) cc_n.c1 = sf_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
      sf_q <= 1'b0;
    end else begin
      cc_q <= cc_n;
      if (sf_evt)   sf_q <= 1'b1;
      else if (clr) sf_q <= 1'b0;
    end
  end

  assign cc      = cc_q;
  assign sf_flag = sf_q;

  AST_STKF_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    sf_evt |=> (sf_flag && (cc.c1 == $past(sf_ovf))));  // R4
  AST_STKF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sf_flag && !clr) |=> sf_flag);  // R4
  AST_CMP_CLEARS_C1: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !sf_evt) |=> !cc.c1);  // R7
  AST_CMP_UNORDERED: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && (cmp_res == 2'b11)) |=> (cc.c3 && cc.c2 && cc.c0));  // R7
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cc_we && !cmp_valid && !sf_evt) |=> (cc == $past(cc_in)));  // R8
endmodule

// File: rtl/fpu_irq_gen.sv
module fpu_irq_gen #(
  parameter int NUM_EXC = fpu_status_pkg::NUM_EXC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] flags_nx,
  input  logic [NUM_EXC-1:0] mask,
  output logic               irq
);
  logic [NUM_EXC-1:0] live;
  logic               irq_q;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_live
    assign live[i] = flags_nx[i] & ~mask[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |live;
  end

  assign irq = irq_q;
endmodule

// File: rtl/fpu_status_unit.sv
module fpu_status_unit
  import fpu_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EXC-1:0]  exc_evt,
  input  logic                stk_fault_evt,
  input  logic                stk_fault_ovf,
  input  logic                cmp_valid,
  input  logic [1:0]          cmp_res,
  input  logic                cc_we,
  input  logic [CC_W-1:0]     cc_in,
  input  logic [TOP_W-1:0]    top_in,
  input  logic                busy_in,
  input  logic [NUM_EXC-1:0]  ctrl_mask,
  input  logic                clr_exc,
  output logic [STATUS_W-1:0] status_word,
  output logic                irq
);
  logic [NUM_EXC-1:0] flags, flags_nx;
  logic               summary, sf_flag;
  ccode_t             cc;
  logic [TOP_W-1:0]   top_q;
  logic               busy_q;

  fpu_exc_flags #(.NUM_EXC(NUM_EXC)) u_flags (
    .clk(clk), .rst(rst), .evt(exc_evt), .clr(clr_exc),
    .flags(flags), .flags_nx(flags_nx), .summary(summary)
  );

  fpu_cond_codes u_cc (
    .clk(clk), .rst(rst), .sf_evt(stk_fault_evt), .sf_ovf(stk_fault_ovf),
    .clr(clr_exc), .cmp_valid(cmp_valid), .cmp_res(cmp_res),
    .cc_we(cc_we), .cc_in(cc_in), .cc(cc), .sf_flag(sf_flag)
  );

  fpu_irq_gen #(.NUM_EXC(NUM_EXC)) u_irq (
    .clk(clk), .rst(rst), .flags_nx(flags_nx), .mask(ctrl_mask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      top_q  <= top_in;
      busy_q <= busy_in;
    end
  end

  assign status_word = {busy_q, cc.c3, top_q, cc.c2, cc.c1, cc.c0,
                        summary, sf_flag, flags};

  AST_UNMASKED_RAISES: assert property (@(posedge clk) disable iff (rst)
    ((exc_evt & ~ctrl_mask) != '0) |=> irq);  // R3
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (clr_exc && (exc_evt == '0)) |=> !irq);  // R6
  AST_TOP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_word[SB_TOPLO +: TOP_W] == $past(top_in)
              && status_word[SB_BUSY] == $past(busy_in)));  // R9
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (status_word == '0 && !irq));  // R10
endmodule

// File: tb/fpu_status_unit_test.sv
`timescale 1ns/1ps
module fpu_status_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  exc_evt = '0;
  logic        stk_fault_evt = 1'b0, stk_fault_ovf = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_res = '0;
  logic        cc_we = 1'b0;
  logic [3:0]  cc_in = '0;
  logic [2:0]  top_in = '0;
  logic        busy_in = 1'b0;
  logic [5:0]  ctrl_mask = 6'h3F;
  logic        clr_exc = 1'b0;
  logic [15:0] status_word;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpu_status_unit uut (
    .clk(clk), .rst(rst), .exc_evt(exc_evt), .stk_fault_evt(stk_fault_evt),
    .stk_fault_ovf(stk_fault_ovf), .cmp_valid(cmp_valid), .cmp_res(cmp_res),
    .cc_we(cc_we), .cc_in(cc_in), .top_in(top_in), .busy_in(busy_in),
    .ctrl_mask(ctrl_mask), .clr_exc(clr_exc), .status_word(status_word), .irq(irq)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ccs(input logic [15:0] s);
    return {s[14], s[10], s[9], s[8]};
  endfunction

  task automatic do_clear();
    clr_exc = 1'b1; cyc(); clr_exc = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) cyc(); rst = 1'b0; cyc();
    chk("R10 status after reset", status_word, 16'h0000);
    chk("R10 irq after reset", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_flag_positions();
    ctrl_mask = 6'h3F;
    for (int i = 0; i < 6; i++) begin
      do_clear();
      exc_evt = 6'(1 << i); cyc(); exc_evt = '0;
      chk("R1 flag position", {10'b0, status_word[5:0]}, 16'(1 << i));
      chk("R5 summary bit", {15'b0, status_word[7]}, 16'h0001);
      chk("R3 masked no irq", {15'b0, irq}, 16'h0000);
      cyc();
      chk("R2 flag held", {10'b0, status_word[5:0]}, 16'(1 << i));
    end
    do_clear();
    exc_evt = 6'b100001; cyc();
    exc_evt = 6'b000100; cyc(); exc_evt = '0; cyc();
    chk("R2 accumulated flags", {10'b0, status_word[5:0]}, 16'h0025);
    do_clear();
    chk("R5 summary cleared", {15'b0, status_word[7]}, 16'h0000);
  endtask

  task automatic t_irq();
    do_clear();
    ctrl_mask = 6'b111011;
    exc_evt = 6'b100000; cyc(); exc_evt = '0;
    chk("R3 masked inexact no irq", {15'b0, irq}, 16'h0000);
    exc_evt = 6'b000100; cyc(); exc_evt = '0;
    chk("R3 unmasked zero-divide irq", {15'b0, irq}, 16'h0001);
    cyc();
    chk("R3 irq held", {15'b0, irq}, 16'h0001);
    do_clear();
    chk("R6 clear drops irq", {15'b0, irq}, 16'h0000);
    chk("R6 clear flags", {8'b0, status_word[7:0]}, 16'h0000);
    ctrl_mask = 6'h3F;
    exc_evt = 6'b100000; cyc(); exc_evt = '0;
    chk("R3 masked set", {15'b0, irq}, 16'h0000);
    ctrl_mask = 6'b011111; cyc();
    chk("R3 late unmask raises irq", {15'b0, irq}, 16'h0001);
    ctrl_mask = 6'h3F; cyc();
    chk("R3 remask lowers irq", {15'b0, irq}, 16'h0000);
    chk("R2 flag kept under mask", {10'b0, status_word[5:0]}, 16'h0020);
    do_clear();
  endtask

  task automatic t_clear_race();
    exc_evt = 6'b000010; cyc();
    clr_exc = 1'b1; exc_evt = 6'b001000; cyc();
    clr_exc = 1'b0; exc_evt = '0;
    chk("R6 same-cycle event kept", {8'b0, status_word[7:0]}, 16'h0088);
    do_clear();
  endtask

  task automatic t_stack();
    do_clear();
    stk_fault_evt = 1'b1; stk_fault_ovf = 1'b1; cyc(); stk_fault_evt = 1'b0;
    chk("R4 stack fault bit", {15'b0, status_word[6]}, 16'h0001);
    chk("R4 overflow sets C1", {15'b0, status_word[9]}, 16'h0001);
    chk("R5 summary ignores stack fault", {15'b0, status_word[7]}, 16'h0000);
    stk_fault_evt = 1'b1; stk_fault_ovf = 1'b0; cyc(); stk_fault_evt = 1'b0;
    chk("R4 underflow clears C1", {15'b0, status_word[9]}, 16'h0000);
    stk_fault_evt = 1'b1; stk_fault_ovf = 1'b1; cmp_valid = 1'b1; cmp_res = 2'b10;
    cyc(); stk_fault_evt = 1'b0; cmp_valid = 1'b0;
    chk("R4 fault beats comparison on C1", ccs(status_word), 16'h000A);
    do_clear();
    chk("R4 clear drops stack fault", {15'b0, status_word[6]}, 16'h0000);
    chk("R6 clear keeps condition codes", ccs(status_word), 16'h000A);
  endtask

  task automatic t_cmp();
    logic [3:0] exp_cc [4] = '{4'b0000, 4'b0001, 4'b1000, 4'b1101};
    for (int r = 0; r < 4; r++) begin
      cc_we = 1'b1; cc_in = 4'b0010; cyc(); cc_we = 1'b0;
      cmp_valid = 1'b1; cmp_res = 2'(r); cyc(); cmp_valid = 1'b0;
      chk("R7 comparison codes", {12'b0, ccs(status_word)}, {12'b0, exp_cc[r]});
    end
  endtask

  task automatic t_ccwrite();
    cc_we = 1'b1; cc_in = 4'b1010; cyc(); cc_we = 1'b0;
    chk("R8 direct write", {12'b0, ccs(status_word)}, 16'h000A);
    chk("R8 bit positions", status_word & 16'h4700, 16'h4200);
    cc_we = 1'b1; cc_in = 4'b0101; cmp_valid = 1'b1; cmp_res = 2'b10; cyc();
    cc_we = 1'b0; cmp_valid = 1'b0;
    chk("R8 comparison beats direct write", {12'b0, ccs(status_word)}, 16'h0008);
  endtask

  task automatic t_top_busy();
    top_in = 3'd5; busy_in = 1'b1; cyc();
    chk("R9 top field", {13'b0, status_word[13:11]}, 16'h0005);
    chk("R9 busy bit", {15'b0, status_word[15]}, 16'h0001);
    top_in = 3'd2; busy_in = 1'b0;
    chk("R9 top held before edge", {13'b0, status_word[13:11]}, 16'h0005);
    cyc();
    chk("R9 top updated", {13'b0, status_word[13:11]}, 16'h0002);
    chk("R9 busy cleared", {15'b0, status_word[15]}, 16'h0000);
    top_in = 3'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc();
    t_reset();
    t_flag_positions();
    t_irq();
    t_clear_race();
    t_stack();
    t_cmp();
    t_ccwrite();
    t_top_busy();
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R10 reset clears word", status_word, 16'h0000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule